// File: doc/BRIEF.md
# Multi-Encoding Signed Adder/Subtractor

This block adds or subtracts two signed words of a parameterised width in any of three encodings: sign-magnitude, ones' complement or two's complement. A two-bit encoding select chooses how both operands and the result are read, and a one-bit operation select chooses between a + b and a - b. The result comes back in the same encoding as the operands, together with a flag that marks results outside the encoding's range. The logic is purely combinational, so the result follows the inputs in the same cycle.

The two complement encodings share one adder path. Subtraction inverts the subtrahend. In two's complement the carry out of the sign position is dropped and subtraction forces a carry-in of one. In ones' complement that carry is fed back into the least significant bit through a second increment stage. Sign-magnitude has its own path. It compares the signs, then adds or subtracts the magnitudes. When the magnitude subtraction borrows, it negates the difference and takes the opposite of the first operand's sign.

Top module: `signed_addsub_multi`

## Requirements
- R1: The most significant bit of each operand and of the result is the sign, 0 for positive and 1 for negative. The encoding select `enc_i` picks 2'b00 sign-magnitude, 2'b01 ones' complement, 2'b10 two's complement; 2'b11 behaves exactly as two's complement.
- R2: With `sub_i` = 0 the result stands for a + b; with `sub_i` = 1 it stands for a - b.
- R3: In two's complement the result equals the true sum or difference modulo 2^WIDTH. The carry out of the sign position is discarded.
- R4: In ones' complement a carry out of the sign position is added back into bit 0. An in-range result decodes to the true value. An out-of-range result decodes to a value congruent to the true value modulo 2^WIDTH - 1.
- R5: In both complement encodings `ovf_o` is 1 exactly when the true result lies outside the encoding's range. That is, the two addends (after the subtrahend is inverted) share a sign and the result sign differs from it.
- R6: In sign-magnitude with equal effective signs the magnitudes are added and the common sign is kept. A carry out of the magnitude field sets `ovf_o` and leaves the low WIDTH-1 bits of the sum as magnitude.
- R7: In sign-magnitude with differing effective signs the result is the exact difference. The sign is that of the operand with the larger magnitude, and `ovf_o` stays 0.
- R8: Sign-magnitude subtraction inverts the subtrahend's sign bit and then follows the rules of R6 and R7.
- R9: A sign-magnitude result with zero magnitude is always returned as all zeros (+0), including after overflow.
- R10: A ones' complement result of all ones (-0) is returned as is and is not turned into +0.
- R11: Only two's complement represents -2^(WIDTH-1) (1 followed by zeros). A result of that value is in range there, while the same true value flags `ovf_o` in the other two encodings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend for subtraction) |
| b_i | input | WIDTH | Second operand (subtrahend for subtraction) |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| enc_i | input | 2 | Encoding select: 00 sign-magnitude, 01 ones' complement, 10/11 two's complement |
| res_o | output | WIDTH | Result in the selected encoding |
| ovf_o | output | 1 | Result outside the encoding's range |

## Verification
The block is combinational, so any fault shows up at `res_o` or `ovf_o` for the very operand pair that reaches it, with no delay. A lost end-around carry makes ones' complement results one too small only when both addends are large enough to carry. A missed borrow correction gives wrapped magnitudes only when the second magnitude is the larger. Because such faults hit only narrow slices of the input space, the sweep covers every operand pair at width 4 in every encoding and for both operations. It checks results against values decoded arithmetically in the bench, and adds directed checks for the -0, +0 and most-negative corners.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the multi-encoding adder/subtractor.
// Assumes nothing beyond a two-bit encoding select.
package sa_pkg;
    // Encoding select values; the last code aliases two's complement.
    typedef enum logic [1:0] {
        ENC_SMAG     = 2'b00,
        ENC_ONES     = 2'b01,
        ENC_TWOS     = 2'b10,
        ENC_TWOS_ALT = 2'b11
    } enc_e;
endpackage

// File: rtl/sa_ripple.sv
`timescale 1ns/1ps
// Module: sa_ripple
// Ripple-carry adder built from generate/propagate cells.
// Assumes W >= 1; the sum is W bits and the final carry is reported.
module sa_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] carry;

    assign carry[0] = cin_i;

    // One full-adder cell per bit, carry chained upward.
    generate
        for (genvar k = 0; k < W; k++) begin : g_cell
            logic gen_k;
            logic prop_k;
            assign gen_k      = x_i[k] & y_i[k];
            assign prop_k     = x_i[k] ^ y_i[k];
            assign sum_o[k]   = prop_k ^ carry[k];
            assign carry[k+1] = gen_k | (prop_k & carry[k]);
        end
    endgenerate

    assign cout_o = carry[W];
endmodule

// File: rtl/sa_cmp_path.sv
`timescale 1ns/1ps
// Module: sa_cmp_path
// Add/subtract for ones' and two's complement words, sign bits included.
// Two's complement drops the final carry; ones' complement feeds it back
// into bit 0 through a second increment stage. Assumes W >= 2.
module sa_cmp_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         ones_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic         cin_main;
    logic [W-1:0] raw_sum;
    logic         raw_cout;
    logic         eac;
    logic [W-1:0] wrap_sum;
    logic         wrap_cout;

    // Subtrahend inverted for subtraction; +1 only in two's complement.
    always_comb begin
        b_eff    = b_i ^ {W{sub_i}};
        cin_main = sub_i & ~ones_i;
    end

    sa_ripple #(.W(W)) u_main (
        .x_i    (a_i),
        .y_i    (b_eff),
        .cin_i  (cin_main),
        .sum_o  (raw_sum),
        .cout_o (raw_cout)
    );

    // End-around carry exists only in ones' complement.
    assign eac = ones_i & raw_cout;

    sa_ripple #(.W(W)) u_wrap (
        .x_i    (raw_sum),
        .y_i    ('0),
        .cin_i  (eac),
        .sum_o  (wrap_sum),
        .cout_o (wrap_cout)
    );

    // Result and sign-rule overflow.
    always_comb begin
        res_o = wrap_sum;
        ovf_o = (a_i[W-1] == b_eff[W-1]) && (wrap_sum[W-1] != a_i[W-1]);
    end

    // Guard: the end-around increment never carries out again.
    always_comb begin
        AST_EAC_SINGLE: assert (!eac || !wrap_cout) else $error("end-around carry rippled out"); // R4
        AST_TWOS_NO_WRAP: assert (ones_i || (wrap_sum == raw_sum)) else $error("two's path altered by wrap stage"); // R3
    end
endmodule

// File: rtl/sa_smag_path.sv
`timescale 1ns/1ps
// Module: sa_smag_path
// Sign-magnitude add/subtract: sign compare, magnitude add or subtract,
// negation of the difference on borrow, zero result forced to +0.
// Assumes W >= 2 (at least one magnitude bit).
module sa_smag_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);
    localparam int M = W - 1;

    logic         sgn_a;
    logic         sgn_b;
    logic         same;
    logic [M-1:0] mag_a;
    logic [M-1:0] mag_b;
    logic [M-1:0] mag_y;
    logic [M-1:0] mag_raw;
    logic         mag_cout;
    logic         borrow;
    logic [M-1:0] mag_neg;
    logic         neg_cout;
    logic [M-1:0] mag_fin;
    logic         sgn_pre;

    // Split fields; subtraction flips the subtrahend sign.
    always_comb begin
        sgn_a = a_i[W-1];
        sgn_b = b_i[W-1] ^ sub_i;
        mag_a = a_i[M-1:0];
        mag_b = b_i[M-1:0];
        same  = (sgn_a == sgn_b);
        mag_y = same ? mag_b : ~mag_b;
    end

    sa_ripple #(.W(M)) u_mag (
        .x_i    (mag_a),
        .y_i    (mag_y),
        .cin_i  (~same),
        .sum_o  (mag_raw),
        .cout_o (mag_cout)
    );

    // Missing carry in the subtract case means the difference went negative.
    assign borrow = ~same & ~mag_cout;

    sa_ripple #(.W(M)) u_neg (
        .x_i    (~mag_raw),
        .y_i    ('0),
        .cin_i  (1'b1),
        .sum_o  (mag_neg),
        .cout_o (neg_cout)
    );

    // Pick corrected magnitude, derive sign, normalise zero to +0.
    always_comb begin
        mag_fin = borrow ? mag_neg : mag_raw;
        sgn_pre = borrow ? ~sgn_a : sgn_a;
        res_o   = (mag_fin == '0) ? '0 : {sgn_pre, mag_fin};
        ovf_o   = same & mag_cout;
    end

    // Guards on the magnitude datapath.
    always_comb begin
        AST_BORROW_NONZERO: assert (!borrow || !neg_cout) else $error("borrow with zero difference"); // R7
        AST_DIFF_MAG_BOUND: assert (same || (mag_fin <= mag_a) || (mag_fin <= mag_b)) else $error("difference exceeds operands"); // R7
    end
endmodule

// File: rtl/signed_addsub_multi.sv
`timescale 1ns/1ps
// Module: signed_addsub_multi (top)
// Combinational add/subtract over sign-magnitude, ones' complement or
// two's complement words, selected per operation. Assumes WIDTH >= 2.
module signed_addsub_multi
    import sa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic [1:0]       enc_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o
);
    enc_e             enc;
    logic             is_smag;
    logic             is_ones;
    logic [WIDTH-1:0] cmp_res;
    logic             cmp_ovf;
    logic [WIDTH-1:0] sm_res;
    logic             sm_ovf;

    // Decode the encoding select.
    always_comb begin
        enc     = enc_e'(enc_i);
        is_smag = (enc == ENC_SMAG);
        is_ones = (enc == ENC_ONES);
    end

    sa_cmp_path #(.W(WIDTH)) u_cmp (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (sub_i),
        .ones_i (is_ones),
        .res_o  (cmp_res),
        .ovf_o  (cmp_ovf)
    );

    sa_smag_path #(.W(WIDTH)) u_smag (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (sub_i),
        .res_o (sm_res),
        .ovf_o (sm_ovf)
    );

    // Route the selected path to the outputs.
    always_comb begin
        res_o = is_smag ? sm_res : cmp_res;
        ovf_o = is_smag ? sm_ovf : cmp_ovf;
    end

    // Port-level guards.
    always_comb begin
        AST_SMAG_NO_NEG_ZERO: assert (!is_smag || (res_o != {1'b1, {(WIDTH-1){1'b0}}})) else $error("sign-magnitude -0 returned"); // R9
        AST_CMP_OVF_SAME_SIGN: assert (is_smag || !ovf_o || (a_i[WIDTH-1] == (b_i[WIDTH-1] ^ sub_i))) else $error("overflow with mixed signs"); // R5
    end
endmodule

// File: tb/signed_addsub_multi_tb.sv
`timescale 1ns/1ps
// Exhaustive bench at WIDTH = 4 with an arithmetic reference model.
module signed_addsub_multi_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic [1:0]   enc;
    logic [W-1:0] res;
    logic         ovf;
    int           n_run  = 0;
    int           n_fail = 0;
    bit           done   = 1'b0;

    always #4 clk = ~clk;

    signed_addsub_multi #(.WIDTH(W)) u_dut (
        .a_i   (a),
        .b_i   (b),
        .sub_i (sub),
        .enc_i (enc),
        .res_o (res),
        .ovf_o (ovf)
    );

    // Integer value of a 4-bit word in encoding m (0 smag, 1 ones, else twos).
    function automatic int decode(logic [3:0] v, int m);
        logic [2:0] low;
        if (m == 0) begin
            low = v[2:0];
            return v[3] ? -int'(low) : int'(low);
        end else if (m == 1) begin
            low = ~v[2:0];
            return v[3] ? -int'(low) : int'(v);
        end
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    task automatic apply(input logic [3:0] ta, input logic [3:0] tb_, input logic ts, input logic [1:0] te);
        @(posedge clk);
        #1;
        a = ta; b = tb_; sub = ts; enc = te;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] exp_r, input logic exp_o);
        n_run++;
        if (res !== exp_r || ovf !== exp_o) begin
            n_fail++;
            $display("FAIL %s: a=%b b=%b sub=%0d enc=%b got res=%b ovf=%b expected res=%b ovf=%b",
                     tag, a, b, sub, enc, res, ovf, exp_r, exp_o);
        end
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0; enc = 2'b00;
        @(negedge clk);
        // Idle check: zero operands give +0 with no overflow (R1 R2).
        check("R1 idle zero", 4'b0000, 1'b0);

        // Exhaustive sweep: every encoding code, both operations, all pairs.
        for (int e = 0; e < 4; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 16; i++) begin
                    for (int j = 0; j < 16; j++) begin
                        int m, x, y, t, lo, d, mag;
                        logic eo;
                        logic [3:0] er;
                        string tag;
                        m = (e >= 2) ? 2 : e;
                        apply(4'(i), 4'(j), s[0], 2'(e));
                        x  = decode(4'(i), m);
                        y  = decode(4'(j), m);
                        t  = (s == 1) ? x - y : x + y;
                        lo = (m == 2) ? -8 : -7;
                        eo = (t < lo) || (t > 7);
                        d  = decode(res, m);
                        if (m == 2) begin
                            // R3 R5 R1 R11: modular result, range flag.
                            tag = (e == 3) ? "R1 code 11 as two's" : (s == 1 ? "R3 R2 two's sub" : "R3 R5 two's add");
                            check(tag, 4'(t), eo);
                        end else if (m == 1) begin
                            // R4 R5: value exact in range, congruent mod 15 otherwise.
                            n_run++;
                            if (ovf !== eo || (!eo && d != t) || (eo && ((d - t) % 15 != 0))) begin
                                n_fail++;
                                $display("FAIL R4 R5 ones: a=%b b=%b sub=%0d got res=%b(%0d) ovf=%b expected value %0d ovf=%b",
                                         a, b, sub, res, d, ovf, t, eo);
                            end
                        end else begin
                            // R6 R7 R8 R9: exact sign-magnitude encoding.
                            mag = (t < 0) ? -t : t;
                            if (mag > 7) mag = mag - 8;
                            er = (mag == 0) ? 4'b0000 : {(t < 0) ? 1'b1 : 1'b0, 3'(mag)};
                            tag = eo ? "R6 smag overflow" : (s == 1 ? "R8 R7 smag sub" : "R6 R7 R9 smag add");
                            check(tag, er, eo);
                        end
                    end
                end
            end
        end

        // Directed corners.
        apply(4'b0001, 4'b1110, 1'b0, 2'b01);
        check("R10 ones -0 kept", 4'b1111, 1'b0);
        apply(4'b0101, 4'b0101, 1'b1, 2'b01);
        check("R10 ones x-x gives -0", 4'b1111, 1'b0);
        apply(4'b1011, 4'b1011, 1'b0, 2'b01);
        check("R11 ones -8 overflows", 4'b0111, 1'b1);
        apply(4'b1100, 4'b1100, 1'b0, 2'b10);
        check("R11 two's -8 in range", 4'b1000, 1'b0);
        apply(4'b1100, 4'b1100, 1'b0, 2'b00);
        check("R11 R9 smag -8 overflow to +0", 4'b0000, 1'b1);
        apply(4'b0011, 4'b1010, 1'b1, 2'b00);
        check("R8 smag 3-(-2)", 4'b0101, 1'b0);
        apply(4'b0010, 4'b1101, 1'b0, 2'b00);
        check("R7 smag 2+(-5)", 4'b1011, 1'b0);
        apply(4'b1011, 4'b1100, 1'b0, 2'b00);
        check("R6 smag -3+-4", 4'b1111, 1'b0);
        apply(4'b1000, 4'b0000, 1'b0, 2'b00);
        check("R9 smag -0+0", 4'b0000, 1'b0);
        apply(4'b0111, 4'b0001, 1'b0, 2'b10);
        check("R5 two's 7+1", 4'b1000, 1'b1);
        apply(4'b0000, 4'b1000, 1'b1, 2'b10);
        check("R3 R5 two's 0-(-8)", 4'b1000, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule